// File: doc/BRIEF.md
# Endpoint Buffer DMA Request Controller

This block sits between one endpoint buffer port and an external DMA engine. When the selected buffer reports ready, it loads the buffer's byte count and raises a request line. It then accepts acknowledge-plus-strobe cycles from the DMA engine. Each accepted cycle moves one transfer unit between the buffer interface and the DMA data bus. A unit is one byte or one halfword, which is two bytes.

A mode input selects the request behaviour. In cycle-steal mode the request is dropped after every accepted unit and raised again if more remains. In burst mode the request is held until the whole buffer has moved. The end-of-transfer signal changes role with direction. When the buffer is read, the block drives it alongside the final unit. When the buffer is written, the block samples it and treats it as a short-packet close. A transaction counter counts completed read buffers.

Top module: `usb_ep_dma_req`

## Requirements
- R1: After reset, `dma_req`, `dma_eot_out`, `buf_pop`, `buf_push` and `buf_done` are low and `txn_count` is zero.
- R2: In cycle-steal mode (`cfg_burst`=0), `dma_req` is low in the cycle after each accepted unit. It is high again the cycle after that if bytes remain and `buf_ready` is high.
- R3: In burst mode (`cfg_burst`=1), `dma_req` stays high from the first accepted unit until the buffer closes. It is low in the cycle after the close.
- R4: With `cfg_wide`=1 a unit is two bytes (`buf_two`=1, data on bits 15:0). A lone trailing byte moves as one byte. With `cfg_wide`=0 every unit is one byte on bits 7:0, and the upper byte is driven as zero.
- R5: A unit is accepted only in a cycle where `dma_req`, `dma_ack`, the selected strobe and `buf_ready` are all high. An accepted unit pulses `buf_pop` (read) or `buf_push` (write).
- R6: With `cfg_one_strb`=1 the selected strobe is `dma_strb`. With `cfg_one_strb`=0 it is `dma_rd_stb` when reading and `dma_wr_stb` when writing. The unselected strobes have no effect.
- R7: `dma_eot_oe` equals `cfg_dir_rd`. When reading, `dma_eot_out` is high exactly while the final unit of the buffer is offered.
- R8: When writing, `dma_eot_in` high during an accepted unit closes the buffer. In that case `buf_done` pulses, `buf_short` is high if bytes were still free, and no further request follows.
- R9: While `buf_ready` is low, `dma_req` is low from the next cycle on.
- R10: `buf_done` pulses with the unit that exhausts the buffer. After a close, no new buffer is loaded until `buf_ready` has been low for at least one cycle.
- R11: `txn_count` increments by one for each closed read buffer. Write buffers leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle-steal |
| cfg_dir_rd | input | 1 | 1 = read buffer to DMA, 0 = write DMA to buffer |
| cfg_wide | input | 1 | 1 = halfword units, 0 = byte units |
| cfg_one_strb | input | 1 | 1 = single shared strobe, 0 = separate read/write strobes |
| buf_ready | input | 1 | Selected buffer ready |
| buf_bytes | input | CW | Bytes held (read) or free (write) when ready |
| buf_rdata | input | DW | Head data of buffer |
| buf_pop | output | 1 | Unit taken from buffer |
| buf_push | output | 1 | Unit written to buffer |
| buf_two | output | 1 | Current unit is two bytes |
| buf_wdata | output | DW | Data toward buffer |
| buf_done | output | 1 | Buffer closed this cycle |
| buf_short | output | 1 | Close was a short packet |
| dma_req | output | 1 | Request to DMA engine |
| dma_ack | input | 1 | DMA acknowledge |
| dma_strb | input | 1 | Shared strobe |
| dma_rd_stb | input | 1 | Read strobe |
| dma_wr_stb | input | 1 | Write strobe |
| dma_rdata | output | DW | Data toward DMA |
| dma_wdata | input | DW | Data from DMA |
| dma_eot_in | input | 1 | End-of-transfer from DMA (write) |
| dma_eot_out | output | 1 | End-of-transfer to DMA (read) |
| dma_eot_oe | output | 1 | Output enable of end-of-transfer pad |
| txn_count | output | TW | Completed read buffers |

## Verification
Several properties are checked on every cycle: the request falls after a cycle-steal unit, stays high between burst units, and is low after a not-ready cycle. The end-of-transfer output is only driven when reading, a read close coincides with that output, a write close leaves the counter alone, and accepted units carry an acknowledge and a ready buffer. Other behaviours are shown only by the bench's scenarios. These are the byte and halfword split of odd lengths, data lane contents, the effect of unselected strobes, short-packet closes at chosen units, the wait for ready to drop between buffers, and the exact counter values.

// File: rtl/uedr_pkg.sv
package uedr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DONE   = 2'd2
    } uedr_st_e;
endpackage

// File: rtl/uedr_strobe_sel.sv
module uedr_strobe_sel (
    input  logic one_strb,
    input  logic dir_rd,
    input  logic strb,
    input  logic rd_stb,
    input  logic wr_stb,
    output logic stb
);
    always_comb begin
        if (one_strb) stb = strb;
        else          stb = dir_rd ? rd_stb : wr_stb;
    end
endmodule

// File: rtl/uedr_unit.sv
module uedr_unit #(
    parameter int CW = 11
) (
    input  logic          wide,
    input  logic [CW-1:0] remain,
    output logic          two,
    output logic          last
);
    always_comb begin
        two  = wide && (remain >= CW'(2));
        last = two ? (remain == CW'(2)) : (remain == CW'(1));
    end
endmodule

// File: rtl/uedr_txn_cnt.sv
module uedr_txn_cnt #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [TW-1:0] count
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/usb_ep_dma_req.sv
module usb_ep_dma_req
    import uedr_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 11,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_burst,
    input  logic          cfg_dir_rd,
    input  logic          cfg_wide,
    input  logic          cfg_one_strb,
    input  logic          buf_ready,
    input  logic [CW-1:0] buf_bytes,
    input  logic [DW-1:0] buf_rdata,
    output logic          buf_pop,
    output logic          buf_push,
    output logic          buf_two,
    output logic [DW-1:0] buf_wdata,
    output logic          buf_done,
    output logic          buf_short,
    output logic          dma_req,
    input  logic          dma_ack,
    input  logic          dma_strb,
    input  logic          dma_rd_stb,
    input  logic          dma_wr_stb,
    output logic [DW-1:0] dma_rdata,
    input  logic [DW-1:0] dma_wdata,
    input  logic          dma_eot_in,
    output logic          dma_eot_out,
    output logic          dma_eot_oe,
    output logic [TW-1:0] txn_count
);
    localparam int HW = DW / 2;

    typedef struct packed {
        uedr_st_e      st;
        logic [CW-1:0] rem;
        logic          req;
    } regs_t;

    regs_t r_d, r_q;
    logic  stb_sel, unit_two, unit_last, xfer, closing;

    uedr_strobe_sel u_stb (
        .one_strb (cfg_one_strb),
        .dir_rd   (cfg_dir_rd),
        .strb     (dma_strb),
        .rd_stb   (dma_rd_stb),
        .wr_stb   (dma_wr_stb),
        .stb      (stb_sel)
    );

    uedr_unit #(.CW(CW)) u_unit (
        .wide   (cfg_wide),
        .remain (r_q.rem),
        .two    (unit_two),
        .last   (unit_last)
    );

    assign xfer    = r_q.req && dma_ack && stb_sel && buf_ready && (r_q.st == ST_ACTIVE);
    assign closing = xfer && (unit_last || (!cfg_dir_rd && dma_eot_in));

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (buf_ready) begin
                    r_d.rem = buf_bytes;
                    r_d.st  = (buf_bytes == '0) ? ST_DONE : ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (closing) begin
                    r_d.rem = '0;
                    r_d.st  = ST_DONE;
                end else if (xfer) begin
                    r_d.rem = r_q.rem - (unit_two ? CW'(2) : CW'(1));
                end
            end
            ST_DONE: begin
                if (!buf_ready) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.req = (r_d.st == ST_ACTIVE) && buf_ready && (r_d.rem != '0)
                  && !(xfer && !cfg_burst);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.rem <= '0;
            r_q.req <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    uedr_txn_cnt #(.TW(TW)) u_txn (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (closing && cfg_dir_rd),
        .count (txn_count)
    );

    assign dma_req     = r_q.req;
    assign buf_pop     = xfer && cfg_dir_rd;
    assign buf_push    = xfer && !cfg_dir_rd;
    assign buf_two     = unit_two;
    assign buf_wdata   = unit_two ? dma_wdata : {{(DW-HW){1'b0}}, dma_wdata[HW-1:0]};
    assign dma_rdata   = unit_two ? buf_rdata : {{(DW-HW){1'b0}}, buf_rdata[HW-1:0]};
    assign buf_done    = closing;
    assign buf_short   = closing && !unit_last;
    assign dma_eot_oe  = cfg_dir_rd;
    assign dma_eot_out = cfg_dir_rd && (r_q.st == ST_ACTIVE) && r_q.req && unit_last;

    p_cs_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !cfg_burst) |=> !dma_req);
    p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && cfg_burst && !closing && buf_ready) |=> dma_req);
    p_accept_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_pop || buf_push) |-> (dma_ack && buf_ready && dma_req));
    p_eot_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_eot_out |-> dma_eot_oe);
    p_rd_close_eot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done && cfg_dir_rd) |-> dma_eot_out);
    p_after_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |=> !dma_req);
    p_notready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_ready |=> !dma_req);
    p_wr_no_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_done && !cfg_dir_rd) |=> $stable(txn_count));
endmodule

// File: tb/usb_ep_dma_req_tb.sv
module usb_ep_dma_req_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int CW = 11;
    localparam int TW = 8;

    logic clk = 0, rst_n = 0;
    logic cfg_burst = 0, cfg_dir_rd = 0, cfg_wide = 0, cfg_one_strb = 0;
    logic buf_ready = 0;
    logic [CW-1:0] buf_bytes = '0;
    logic [DW-1:0] buf_rdata = '0, dma_wdata = '0;
    logic dma_ack = 0, dma_strb = 0, dma_rd_stb = 0, dma_wr_stb = 0, dma_eot_in = 0;
    logic buf_pop, buf_push, buf_two, buf_done, buf_short, dma_req, dma_eot_out, dma_eot_oe;
    logic [DW-1:0] buf_wdata, dma_rdata;
    logic [TW-1:0] txn_count;

    int n_chk = 0, n_fail = 0, exp_txn = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_ep_dma_req #(.DW(DW), .CW(CW), .TW(TW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_two(input bit wide, input int rem);
        return wide && rem >= 2;
    endfunction

    function automatic logic [DW-1:0] exp_lane(input bit two, input logic [DW-1:0] v);
        return two ? v : {8'h00, v[7:0]};
    endfunction

    task automatic idle_inputs();
        dma_ack = 0; dma_strb = 0; dma_rd_stb = 0; dma_wr_stb = 0; dma_eot_in = 0;
    endtask

    task automatic run_buf(input bit rd, input bit burst, input bit wide, input bit one,
                           input int n, input int eot_at, input int drop_at);
        int rem = n, unit = 0, waits = 0;
        bit prev_x = 0, cs_hi = 0, dropped = 0, tried_wrong = 0;
        cfg_dir_rd = rd; cfg_burst = burst; cfg_wide = wide; cfg_one_strb = one;
        buf_bytes = CW'(n); buf_ready = 1;
        while (rem > 0) begin
            @(negedge clk);
            idle_inputs();
            chk(dma_eot_oe == rd, "R7 oe", dma_eot_oe, rd);
            if (prev_x) begin
                prev_x = 0;
                if (burst) chk(dma_req == 1, "R3 hold", dma_req, 1);
                else begin chk(dma_req == 0, "R2 drop", dma_req, 0); cs_hi = 1; continue; end
            end else if (cs_hi) begin
                cs_hi = 0;
                chk(dma_req == 1, "R2 return", dma_req, 1);
            end
            if (unit == drop_at && !dropped) begin
                dropped = 1; buf_ready = 0;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    if (k > 0) chk(dma_req == 0, "R9 notready", dma_req, 0);
                end
                buf_ready = 1;
                continue;
            end
            if (!dma_req) begin
                waits++;
                if (waits > 20) begin chk(0, "R5 no request", 0, 1); return; end
                continue;
            end
            waits = 0;
            if (!tried_wrong) begin
                tried_wrong = 1;
                // wrong strobes with ack, then right strobe without ack
                dma_ack = 1;
                if (one) begin dma_rd_stb = 1; dma_wr_stb = 1; end
                else begin dma_strb = 1; if (rd) dma_wr_stb = 1; else dma_rd_stb = 1; end
                #1;
                chk(!buf_pop && !buf_push, "R6 unselected strobe", {buf_pop, buf_push}, 0);
                @(negedge clk);
                idle_inputs();
                if (one) dma_strb = 1; else if (rd) dma_rd_stb = 1; else dma_wr_stb = 1;
                #1;
                chk(!buf_pop && !buf_push, "R5 no ack", {buf_pop, buf_push}, 0);
                continue;
            end
            begin
                bit two = exp_two(wide, rem);
                bit last = (rem == (two ? 2 : 1));
                bit eot = !rd && (unit == eot_at);
                bit closes = last || eot;
                logic [DW-1:0] d = DW'($urandom);
                dma_ack = 1;
                if (one) dma_strb = 1; else if (rd) dma_rd_stb = 1; else dma_wr_stb = 1;
                dma_eot_in = eot;
                buf_rdata = d; dma_wdata = d;
                #1;
                chk(buf_pop == rd && buf_push == !rd, "R5 accept", {buf_pop, buf_push}, {rd, !rd});
                chk(buf_two == two, "R4 unit size", buf_two, two);
                if (rd) chk(dma_rdata == exp_lane(two, d), "R4 read lane", dma_rdata, exp_lane(two, d));
                else    chk(buf_wdata == exp_lane(two, d), "R4 write lane", buf_wdata, exp_lane(two, d));
                if (rd) chk(dma_eot_out == last, "R7 eot out", dma_eot_out, last);
                chk(buf_done == closes, "R10 done", buf_done, closes);
                chk(buf_short == (closes && !last), "R8 short", buf_short, closes && !last);
                rem = closes ? 0 : rem - (two ? 2 : 1);
                unit++;
                prev_x = 1;
                if (closes && rd) exp_txn = (exp_txn + 1) % 256;
            end
        end
        @(negedge clk);
        idle_inputs();
        chk(dma_req == 0, "R8 no request after close", dma_req, 0);
        @(negedge clk);
        chk(dma_req == 0, "R10 wait for ready low", dma_req, 0);
        buf_ready = 0;
        @(negedge clk);
        @(negedge clk);
        chk(dma_req == 0, "R9 idle not ready", dma_req, 0);
        chk(int'(txn_count) == exp_txn, "R11 txn count", txn_count, exp_txn);
    endtask

    initial begin
        repeat (CLK_PERIOD * 100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!dma_req && !dma_eot_out && !buf_pop && !buf_push && !buf_done && txn_count == 0,
            "R1 reset", {dma_req, dma_eot_out, buf_pop, buf_push, buf_done}, 0);
        rst_n = 1;
        @(negedge clk);
        // directed corners
        run_buf(1, 0, 1, 1, 5, -1, -1);   // odd length, halfword, cycle steal
        run_buf(1, 1, 1, 0, 6, -1, 2);    // burst with not-ready gap
        run_buf(0, 1, 0, 0, 4, -1, -1);   // byte write, burst
        run_buf(0, 0, 1, 1, 10, 2, -1);   // short packet close
        run_buf(0, 1, 1, 0, 1, -1, -1);   // single byte write
        run_buf(1, 0, 0, 0, 1, -1, -1);   // single byte read
        for (int i = 0; i < 50; i++) begin
            bit rd = 1'($urandom);
            int n = 1 + int'($urandom % 20);
            int e = (($urandom % 3) == 0) ? int'($urandom % 12) : -1;
            int dp = (($urandom % 4) == 0) ? 1 + int'($urandom % 5) : -1;
            run_buf(rd, 1'($urandom), 1'($urandom), 1'($urandom), n, e, dp);
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule